// File: doc/BRIEF.md
# Supply Rail Enable and Protection Sequencer

This block is the digital control core of a multi-rail automotive supply. A serial-bus slave hands it single-byte register writes (address and data with a one-cycle strobe), and clean digital detector flags arrive from the analog side. From these it keeps the per-rail enable register, the per-rail output-level codes and the detector configuration. It gates the rail enables with the protection events. It also drives the always-on core regulator enable, an open fault flag pin and a 16-bit status word for readback.

Six switched rails are controlled: a lamp regulator, a disc-drive regulator, a sound regulator, a system regulator and two high-side switches (A and B). An output-level code can only change while its rail is off, so a stray write cannot shift a live supply. Over-voltage protection, low-input shutdown and thermal shutdown wipe the enable register, and the rails stay dark until software enables them again. The fault pin merges the detectors under a 2-bit mode mask. The status word always shows the raw detector state, whatever the mode.

Top module: `rail_guard_ctrl`

## Requirements
- R1: After reset every rail enable, output-level code, threshold code and the flag mode are 0, `core_on` is 1, and with no detector active `flag_out` is 1 and `status_word` equals the live `det_v6_present` bit at position 8 only.
- R2: A write to address 0 loads data bits 7..2 into the rail enables (bit7 lamp, bit6 disc, bit5 sound, bit4 system, bit3 switch A, bit2 switch B; 1 = on), which appear on `rail_on[5:0]` in that order from the clock edge that takes the write.
- R3: A write to address 1 loads data[7:6] into the lamp code, [5:4] into the disc code, [3:2] into the sound code and bit1 into `sys_sel`, each only if its rail's enable bit is 0; the field of an enabled rail keeps its old value.
- R4: A write to address 2 loads data[7:6] into `acc_thr`, [5:4] into `uv_thr` and [3:2] into the flag mode; without such a write the three fields hold.
- R5: While `det_ovp` or `det_v6_sdn` is 1, every `rail_on` bit is 0 in the same cycle and the enable register is cleared; enable writes in that time are discarded and the rails stay off after the event ends until address 0 is written again.
- R6: While `det_v6_low` is 1, writes to address 0 leave the enable register unchanged; writes to addresses 1 and 2 are still accepted.
- R7: While `det_tsd` is 1, `core_on` is 0, every `rail_on` bit is 0 and the enable register is cleared; `core_on` returns to 1 as soon as `det_tsd` falls, and the rails stay off.
- R8: `status_word[15:8]` is {lamp code, disc code, sound code, `sys_sel`, `det_v6_present`}.
- R9: `status_word[7:0]` is {`det_acc_low`, `det_uv`, `det_ov`, `det_ovp`, `det_v6_sdn`, OR of the six `det_oc` bits, 0, 0}, live in every flag mode; `det_vdd_oc` and `det_tsd` do not appear there.
- R10: In flag mode 00, `flag_out` is 0 whenever any of ACC-low, UV, OV, OVP, TSD or core over-current is active, and 1 otherwise.
- R11: In flag mode 01, only ACC-low, TSD and core over-current pull `flag_out` to 0; UV, OV and OVP are ignored.
- R12: In flag modes 10 and 11, UV, OV, OVP, TSD and core over-current pull `flag_out` to 0; ACC-low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 2 | Register address (0 enables, 1 levels, 2 config) |
| wr_data | input | 8 | Register write data |
| det_ovp | input | 1 | Input over-voltage protection active |
| det_v6_sdn | input | 1 | Low-voltage input collapsed (shutdown) |
| det_v6_low | input | 1 | Low-voltage input below enable threshold |
| det_v6_present | input | 1 | Core regulator fed from the low-voltage input |
| det_uv | input | 1 | Battery under-voltage |
| det_ov | input | 1 | Battery over-voltage |
| det_acc_low | input | 1 | Accessory line below threshold |
| det_tsd | input | 1 | Thermal shutdown |
| det_oc | input | 6 | Per-rail over-current, same order as rail_on |
| det_vdd_oc | input | 1 | Core regulator over-current |
| rail_on | output | 6 | Rail enables: lamp, disc, sound, system, switch A, switch B |
| lamp_code | output | 2 | Lamp regulator level code |
| disc_code | output | 2 | Disc regulator level code |
| sound_code | output | 2 | Sound regulator level code |
| sys_sel | output | 1 | System regulator level select |
| core_on | output | 1 | Core regulator enable |
| acc_thr | output | 2 | Accessory detector threshold code |
| uv_thr | output | 2 | Under-voltage detector threshold code |
| flag_out | output | 1 | Fault flag pin, 1 = healthy |
| status_word | output | 16 | Readback word |

## Verification
On every cycle the assertions hold that a killing event forces all rails off at once and clears the enable register, that enable writes during a low input leave the register as it was, that an enabled rail's level code cannot move, that the configuration fields hold without a write, and that thermal shutdown or core over-current always pulls the flag low and drops the core enable. The bench scenarios are needed to show that the rails stay off after an event until a new enable write arrives. They also show that each mode mask keeps or drops the right detectors on the flag pin, and that every status field sits at its stated bit position.

// File: rtl/rail_guard_pkg.sv
package rail_guard_pkg;
   typedef enum logic [1:0] {
      FM_ALL  = 2'b00,
      FM_ACC  = 2'b01,
      FM_BAT0 = 2'b10,
      FM_BAT1 = 2'b11
   } flag_mode_e;

   localparam logic [1:0] RG_ADDR_EN  = 2'd0;
   localparam logic [1:0] RG_ADDR_LVL = 2'd1;
   localparam logic [1:0] RG_ADDR_CFG = 2'd2;
endpackage

// File: rtl/rg_enable_reg.sv
module rg_enable_reg #(
   parameter int RAILS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [RAILS-1:0] wr_bits,
   input  logic             kill,
   input  logic             in_low,
   output logic [RAILS-1:0] en_q,
   output logic [RAILS-1:0] rail_on
);
   if (RAILS < 1) begin : g_bad_rails
      $error("rg_enable_reg: RAILS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 en_q <= '0;
      else if (kill)              en_q <= '0;
      else if (wr_stb && !in_low) en_q <= wr_bits;
   end

   assign rail_on = kill ? '0 : en_q;

   assert_kill_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      kill |-> (rail_on == '0));
   assert_kill_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(kill) |-> (en_q == '0));
   assert_low_rejects_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && in_low && !kill) |=> $stable(en_q));
endmodule

// File: rtl/rg_level_reg.sv
module rg_level_reg #(
   parameter int FIELDS = 3,
   parameter int CODE_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb,
   input  logic [FIELDS*CODE_W:0]   wr_bits,
   input  logic [FIELDS:0]          en_i,
   output logic [FIELDS*CODE_W-1:0] codes_o,
   output logic                     sel_o
);
   localparam int TOP = FIELDS * CODE_W;

   if (FIELDS < 1 || CODE_W < 1) begin : g_bad_shape
      $error("rg_level_reg: FIELDS and CODE_W must be positive");
   end

   for (genvar i = 0; i < FIELDS; i++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            codes_o[TOP-1-i*CODE_W -: CODE_W] <= '0;
         else if (wr_stb && !en_i[FIELDS-i])
            codes_o[TOP-1-i*CODE_W -: CODE_W] <= wr_bits[TOP-i*CODE_W -: CODE_W];
      end

      assert_locked_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
         en_i[FIELDS-i] |=> $stable(codes_o[TOP-1-i*CODE_W -: CODE_W]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   sel_o <= 1'b0;
      else if (wr_stb && !en_i[0])  sel_o <= wr_bits[0];
   end

   assert_locked_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_i[0] |=> $stable(sel_o));
endmodule

// File: rtl/rg_flag_comb.sv
module rg_flag_comb
   import rail_guard_pkg::*;
#(
   parameter bit REGISTERED = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  flag_mode_e mode,
   input  logic       acc_low,
   input  logic       uv,
   input  logic       ov,
   input  logic       ovp,
   input  logic       hard_fault,
   output logic       flag
);
   logic acc_counts, bat_counts, fault;

   assign acc_counts = (mode == FM_ALL) || (mode == FM_ACC);
   assign bat_counts = (mode != FM_ACC);
   assign fault = (acc_low && acc_counts) || ((uv || ov || ovp) && bat_counts) || hard_fault;

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag <= 1'b1;
         else        flag <= !fault;
      end
      assert_hard_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
         hard_fault |=> !flag);
   end else begin : g_comb
      assign flag = !fault;
      assert_hard_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
         hard_fault |-> !flag);
      assert_mode_acc_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == FM_ACC && !acc_low && !hard_fault) |-> flag);
   end
endmodule

// File: rtl/rail_guard_ctrl.sv
module rail_guard_ctrl
   import rail_guard_pkg::*;
#(
   parameter int RAILS    = 6,
   parameter int FIELDS   = 3,
   parameter int CODE_W   = 2,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 2,
   parameter bit FLAG_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 det_ovp,
   input  logic                 det_v6_sdn,
   input  logic                 det_v6_low,
   input  logic                 det_v6_present,
   input  logic                 det_uv,
   input  logic                 det_ov,
   input  logic                 det_acc_low,
   input  logic                 det_tsd,
   input  logic [RAILS-1:0]     det_oc,
   input  logic                 det_vdd_oc,
   output logic [RAILS-1:0]     rail_on,
   output logic [CODE_W-1:0]    lamp_code,
   output logic [CODE_W-1:0]    disc_code,
   output logic [CODE_W-1:0]    sound_code,
   output logic                 sys_sel,
   output logic                 core_on,
   output logic [CODE_W-1:0]    acc_thr,
   output logic [CODE_W-1:0]    uv_thr,
   output logic                 flag_out,
   output logic [2*DATA_W-1:0]  status_word
);
   localparam int LVL_W = FIELDS * CODE_W;
   localparam int CFG_W = 3 * CODE_W;

   if (DATA_W != 8 || RAILS != 6 || FIELDS != 3 || CODE_W != 2 || ADDR_W != 2) begin : g_bad_layout
      $error("rail_guard_ctrl: register layout requires 8-bit data, 6 rails, 3 two-bit fields");
   end

   logic             kill;
   logic [RAILS-1:0] en_q;
   logic [LVL_W-1:0] codes;
   logic [CFG_W-1:0] cfg_q;
   flag_mode_e       mode;
   logic             unused_bit0;

   assign kill        = det_ovp || det_v6_sdn || det_tsd;
   assign unused_bit0 = wr_data[0];

   rg_enable_reg #(.RAILS(RAILS)) u_en (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_en && wr_addr == RG_ADDR_EN),
      .wr_bits(wr_data[DATA_W-1 -: RAILS]),
      .kill(kill), .in_low(det_v6_low),
      .en_q(en_q), .rail_on(rail_on)
   );

   rg_level_reg #(.FIELDS(FIELDS), .CODE_W(CODE_W)) u_lvl (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_en && wr_addr == RG_ADDR_LVL),
      .wr_bits(wr_data[DATA_W-1 -: LVL_W+1]),
      .en_i(en_q[RAILS-1 -: FIELDS+1]),
      .codes_o(codes), .sel_o(sys_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cfg_q <= '0;
      else if (wr_en && wr_addr == RG_ADDR_CFG) cfg_q <= wr_data[DATA_W-1 -: CFG_W];
   end

   assign acc_thr = cfg_q[CFG_W-1 -: CODE_W];
   assign uv_thr  = cfg_q[CFG_W-1-CODE_W -: CODE_W];
   assign mode    = flag_mode_e'(cfg_q[CODE_W-1:0]);

   assign lamp_code  = codes[LVL_W-1 -: CODE_W];
   assign disc_code  = codes[LVL_W-1-CODE_W -: CODE_W];
   assign sound_code = codes[CODE_W-1:0];

   rg_flag_comb #(.REGISTERED(FLAG_REG)) u_flag (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .acc_low(det_acc_low), .uv(det_uv), .ov(det_ov), .ovp(det_ovp),
      .hard_fault(det_tsd || det_vdd_oc),
      .flag(flag_out)
   );

   assign core_on = !det_tsd;

   assign status_word = {codes, sys_sel, det_v6_present,
                         det_acc_low, det_uv, det_ov, det_ovp, det_v6_sdn,
                         |det_oc, 2'b00};

   assert_tsd_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      det_tsd |-> (!core_on && rail_on == '0));
   assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == RG_ADDR_CFG) |=> $stable({acc_thr, uv_thr}));
endmodule

// File: tb/sim_rail_guard_ctrl.sv
`timescale 1ns/1ps
module sim_rail_guard_ctrl;
   localparam int CLK_NS = 8;
   localparam int NV = 16;
   // {mode[1:0], acc, uv, ov, ovp, tsd, vdd_oc, expected flag}
   localparam logic [8:0] VEC [NV] = '{
      9'b00_000000_1, 9'b00_100000_0, 9'b00_010000_0, 9'b00_001000_0,
      9'b00_000100_0, 9'b01_100000_0, 9'b01_010000_1, 9'b01_001000_1,
      9'b01_000100_1, 9'b01_000010_0, 9'b10_100000_1, 9'b10_010000_0,
      9'b11_100000_1, 9'b11_001000_0, 9'b11_000001_0, 9'b00_000001_0
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic det_ovp = 0, det_v6_sdn = 0, det_v6_low = 0, det_v6_present = 0;
   logic det_uv = 0, det_ov = 0, det_acc_low = 0, det_tsd = 0, det_vdd_oc = 0;
   logic [5:0] det_oc = '0;
   logic [5:0] rail_on;
   logic [1:0] lamp_code, disc_code, sound_code, acc_thr, uv_thr;
   logic sys_sel, core_on, flag_out;
   logic [15:0] status_word;
   int n_vec = 0, n_bad = 0;

   always #(CLK_NS/2) clk = ~clk;

   rail_guard_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .det_ovp(det_ovp), .det_v6_sdn(det_v6_sdn), .det_v6_low(det_v6_low),
      .det_v6_present(det_v6_present), .det_uv(det_uv), .det_ov(det_ov),
      .det_acc_low(det_acc_low), .det_tsd(det_tsd), .det_oc(det_oc),
      .det_vdd_oc(det_vdd_oc), .rail_on(rail_on), .lamp_code(lamp_code),
      .disc_code(disc_code), .sound_code(sound_code), .sys_sel(sys_sel),
      .core_on(core_on), .acc_thr(acc_thr), .uv_thr(uv_thr),
      .flag_out(flag_out), .status_word(status_word)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rail_on", 16'(rail_on), 16'h0);
      chk("R1 codes", {9'b0, lamp_code, disc_code, sound_code, sys_sel}, 16'h0);
      chk("R1 thresholds", {12'b0, acc_thr, uv_thr}, 16'h0);
      chk("R1 core/flag", {14'b0, core_on, flag_out}, 16'h3);
      chk("R1 status", status_word, 16'h0000);

      // R2 enable loads
      wr(2'd0, 8'hFC);
      chk("R2 all on", 16'(rail_on), 16'h3F);
      wr(2'd0, 8'h0C);
      chk("R2 switches only", 16'(rail_on), 16'h03);
      wr(2'd0, 8'hA4);
      chk("R2 mixed", 16'(rail_on), 16'h29);

      // R3 lock of enabled fields, R8 high byte
      wr(2'd1, 8'hFE);
      chk("R3 locked/unlocked", {9'b0, lamp_code, disc_code, sound_code, sys_sel}, 16'b0000000_00_11_00_1);
      chk("R8 high byte", status_word, 16'h3200);
      wr(2'd0, 8'h00);
      det_v6_present = 1'b1;
      wr(2'd1, 8'hE4);
      chk("R3 all unlocked", {9'b0, lamp_code, disc_code, sound_code, sys_sel}, 16'b0000000_11_10_01_0);
      chk("R8 high byte v6", status_word, 16'hE500);

      // R4 config
      wr(2'd2, 8'hB4);
      chk("R4 thresholds", {12'b0, acc_thr, uv_thr}, 16'h000B);
      @(negedge clk); det_uv = 1'b1; #1;
      chk("R4 mode 01 masks uv", 16'(flag_out), 16'h1);
      @(negedge clk); det_uv = 1'b0;
      wr(2'd2, 8'h00);

      // R6 low input rejects enable writes
      wr(2'd0, 8'h80);
      det_v6_low = 1'b1;
      wr(2'd0, 8'h04);
      chk("R6 enable write rejected", 16'(rail_on), 16'h20);
      wr(2'd2, 8'h40);
      chk("R6 config accepted", 16'(acc_thr), 16'h1);
      det_v6_low = 1'b0;
      wr(2'd1, 8'h10);
      chk("R6 level on unlocked disc", 16'(disc_code), 16'h1);

      // R5 over-voltage protection
      wr(2'd0, 8'hFC);
      @(negedge clk); det_ovp = 1'b1; #1;
      chk("R5 ovp same cycle off", 16'(rail_on), 16'h0);
      wr(2'd0, 8'hFC);
      chk("R5 write during ovp", 16'(rail_on), 16'h0);
      det_ovp = 1'b0;
      @(negedge clk);
      chk("R5 off after ovp", 16'(rail_on), 16'h0);
      wr(2'd0, 8'hFC);
      chk("R5 rewrite restores", 16'(rail_on), 16'h3F);
      @(negedge clk); det_v6_sdn = 1'b1; #1;
      chk("R5 sdn off", 16'(rail_on), 16'h0);
      chk("R9 sdn bit", 16'(status_word[7:0]), 16'h08);
      @(negedge clk); det_v6_sdn = 1'b0;
      @(negedge clk);
      chk("R5 off after sdn", 16'(rail_on), 16'h0);

      // R7 thermal shutdown
      wr(2'd0, 8'hFC);
      @(negedge clk); det_tsd = 1'b1; #1;
      chk("R7 tsd dark", {9'b0, core_on, rail_on}, 16'h0);
      @(negedge clk); det_tsd = 1'b0; #1;
      chk("R7 core back, rails off", {9'b0, core_on, rail_on}, 16'h40);

      // R9 over-current summary
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); det_oc = 6'(1 << i); #1;
         chk("R9 oc bit", 16'(status_word[7:0]), 16'h04);
      end
      @(negedge clk); det_oc = '0; det_vdd_oc = 1'b1; #1;
      chk("R9 core oc not in status", 16'(status_word[7:0]), 16'h00);
      chk("R10 core oc pulls flag", 16'(flag_out), 16'h0);
      @(negedge clk); det_vdd_oc = 1'b0;

      // R10/R11/R12 flag mode table, R9 live status
      for (int v = 0; v < NV; v++) begin
         wr(2'd2, {4'b0, VEC[v][8:7], 2'b0});
         {det_acc_low, det_uv, det_ov, det_ovp, det_tsd, det_vdd_oc} = VEC[v][6:1];
         #1;
         chk(VEC[v][8] ? "R12 flag" : (VEC[v][7] ? "R11 flag" : "R10 flag"),
             16'(flag_out), 16'(VEC[v][0]));
         chk("R9 status live", 16'(status_word[7:0]), {8'b0, VEC[v][6:3], 4'b0});
         @(negedge clk);
         {det_acc_low, det_uv, det_ov, det_ovp, det_tsd, det_vdd_oc} = '0;
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule